// File: doc/BRIEF.md
# Oscillator Mode Controller with Holdover Averaging

This block decides which frequency word drives the numerically controlled oscillator of a digital phase-locked loop. It has three operating modes. In Free-Run the oscillator runs from the system clock with a fixed nominal word. In Locked it follows the word produced by the loop filter. In Holdover it replays a smoothed history of the words seen while the loop was locked. The block sits between the loop filter and the oscillator. A separate reference monitor and lock detector supply its qualification inputs.

The loop filter delivers its words as a stream that carries a valid strobe, `upd_tick`, and no ready. The controller takes a word on every cycle in which the strobe is high and can never apply back-pressure, so the filter never has to stall. The reference-valid and lock-detect inputs are sampled only on strobe cycles. The force control acts on every cycle. While Locked, an exponential average with a programmable shift follows the loop word. That average counts as usable holdover data only after a programmable number of locked updates. The output word and the mode code are registered state and need no handshake.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: After reset, `mode_code` is 00 (Free-Run) and `nco_word` equals the parameter `NOM_WORD`.
- R2: From Free-Run, the mode becomes Locked (01) at the edge of the strobe cycle on which `ref_ok` and `lock_in` have both been high for `lock_ticks` consecutive strobe cycles. A value of 0 or 1 means the first such cycle. A strobe cycle without both inputs high restarts the count.
- R3: While Locked, `nco_word` equals the `loop_word` taken on the most recent strobe cycle. It updates at the edge of that cycle.
- R4: On each strobe cycle in Locked with both inputs high and force low, the average becomes avg + floor((loop_word - avg) / 2^avg_shift). It restarts at `NOM_WORD` whenever the mode is Free-Run. In Holdover, `nco_word` equals the average and does not change.
- R5: In Locked, a strobe cycle without both `ref_ok` and `lock_in` moves the mode to Holdover (10), provided at least `hold_min` averaging updates have occurred since Locked was entered from Free-Run.
- R6: Under the same loss with fewer than `hold_min` updates, the mode goes to Free-Run and `nco_word` returns to `NOM_WORD`.
- R7: In Holdover, a strobe cycle with both `ref_ok` and `lock_in` high returns the mode to Locked at once, with no qualification count.
- R8: `force_free` high on any cycle makes the mode Free-Run at the next edge. It clears the lock count and the holdover data, and blocks locking while it is high.
- R9: `mode_code` takes only the values 00 Free-Run, 01 Locked and 10 Holdover, and never 11.
- R10: Changes on `ref_ok`, `lock_in` and `loop_word` in cycles without a strobe have no effect on `mode_code` or `nco_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_tick | input | 1 | Valid strobe for `loop_word`; also the sampling instant for the qualifiers |
| loop_word | input | FW_W | Frequency word from the loop filter |
| ref_ok | input | 1 | Selected reference is valid |
| lock_in | input | 1 | Lock detector output |
| force_free | input | 1 | Force Free-Run; overrides everything else |
| lock_ticks | input | CNT_W | Consecutive qualifying strobes needed to enter Locked |
| hold_min | input | CNT_W | Locked updates needed before the holdover data is usable |
| avg_shift | input | SHIFT_W | Right-shift of the exponential average |
| nco_word | output | FW_W | Frequency word applied to the oscillator |
| mode_code | output | 2 | 00 Free-Run, 01 Locked, 10 Holdover |

## Verification
The hardest case to reach from the ports is a loss of reference on exactly the strobe where the locked-update count equals `hold_min`, or one short of it, because that single update decides between Holdover and Free-Run. Directed sequences count strobes up to both sides of that threshold. Random phases then redraw `hold_min`, `lock_ticks` and `avg_shift` to small values and drop the reference rarely. This produces many losses at assorted counts, and each cycle is compared with a bench model of mode, average and output word.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_LOCK = 2'b01,
    MODE_HOLD = 2'b10
  } dmc_mode_e;
endpackage

// File: rtl/dmc_lock_qual.sv
module dmc_lock_qual #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             good,
  input  logic             force_fr,
  input  logic [CNT_W-1:0] lock_ticks,
  output logic             qual
);
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] run_inc;

  // saturating increment of the consecutive-good counter
  assign run_inc = (&run_cnt) ? run_cnt : run_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_cnt <= '0;
    else if (force_fr) run_cnt <= '0;
    else if (tick)     run_cnt <= good ? run_inc : '0;
  end

  assign qual = tick & good & ~force_fr & (run_inc >= lock_ticks);

  // R2: a strobe without qualification restarts the count
  p_count_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !good) |=> (run_cnt == '0));

  // R8: force clears the count
  p_force_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_fr |=> (run_cnt == '0));
endmodule

// File: rtl/dmc_hold_avg.sv
module dmc_hold_avg
  import dmc_pkg::*;
#(
  parameter int          FW_W     = 24,
  parameter int          SHIFT_W  = 5,
  parameter int          CNT_W    = 16,
  parameter logic [FW_W-1:0] NOM_WORD = 24'h800000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dmc_mode_e          mode,
  input  logic               learn,
  input  logic [FW_W-1:0]    word,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [CNT_W-1:0]   hold_min,
  output logic [FW_W-1:0]    avg,
  output logic               hold_ok
);
  localparam int EW = FW_W + 2;

  logic signed [EW-1:0] diff;
  logic signed [EW-1:0] step;
  logic signed [EW-1:0] sum;
  logic [CNT_W-1:0]     upd_cnt;
  logic                 do_upd;

  assign diff   = $signed({2'b00, word}) - $signed({2'b00, avg});
  assign step   = diff >>> shift;
  assign sum    = $signed({2'b00, avg}) + step;
  assign do_upd = learn && (mode == MODE_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avg     <= NOM_WORD;
      upd_cnt <= '0;
    end else if (mode == MODE_FREE) begin
      avg     <= NOM_WORD;
      upd_cnt <= '0;
    end else if (do_upd) begin
      avg     <= sum[FW_W-1:0];
      upd_cnt <= (&upd_cnt) ? upd_cnt : upd_cnt + 1'b1;
    end
  end

  assign hold_ok = (upd_cnt >= hold_min);

  // R4: holdover data is frozen while in Holdover
  p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && $past(mode) == MODE_HOLD) |-> $stable(avg));

  // R4: each update moves the average toward the word, never past it
  p_avg_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(do_upd) |->
      ((avg >= $past(avg) && avg <= $past(word)) ||
       (avg <= $past(avg) && avg >= $past(word))));
endmodule

// File: rtl/dmc_mode_fsm.sv
module dmc_mode_fsm
  import dmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      good,
  input  logic      force_fr,
  input  logic      qual,
  input  logic      hold_ok,
  output dmc_mode_e mode
);
  dmc_mode_e mode_nx;

  always_comb begin
    mode_nx = mode;
    if (force_fr) begin
      mode_nx = MODE_FREE;
    end else if (tick) begin
      unique case (mode)
        MODE_FREE: if (qual)  mode_nx = MODE_LOCK;
        MODE_LOCK: if (!good) mode_nx = hold_ok ? MODE_HOLD : MODE_FREE;
        MODE_HOLD: if (good)  mode_nx = MODE_LOCK;
        default:              mode_nx = MODE_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= MODE_FREE;
    else        mode <= mode_nx;
  end

  // R8: force wins on the next edge
  p_force_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_fr |=> (mode == MODE_FREE));

  // R9: only three legal codes
  p_mode_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  // R5: entering Holdover needs usable data
  p_hold_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && $past(mode) == MODE_LOCK) |-> $past(hold_ok));

  // R7: leaving Holdover needs a qualified strobe
  p_relock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOCK && $past(mode) == MODE_HOLD) |-> $past(tick && good));

  // R10: no transition without a strobe unless forced
  p_tick_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_fr) |=> $stable(mode));
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dmc_pkg::*;
#(
  parameter int              FW_W     = 24,
  parameter int              SHIFT_W  = 5,
  parameter int              CNT_W    = 16,
  parameter logic [FW_W-1:0] NOM_WORD = 24'h800000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_tick,
  input  logic [FW_W-1:0]    loop_word,
  input  logic               ref_ok,
  input  logic               lock_in,
  input  logic               force_free,
  input  logic [CNT_W-1:0]   lock_ticks,
  input  logic [CNT_W-1:0]   hold_min,
  input  logic [SHIFT_W-1:0] avg_shift,
  output logic [FW_W-1:0]    nco_word,
  output logic [1:0]         mode_code
);
  dmc_mode_e       mode;
  logic            good;
  logic            qual;
  logic            hold_ok;
  logic            learn;
  logic [FW_W-1:0] avg;
  logic [FW_W-1:0] last_word;

  assign good  = ref_ok & lock_in;
  assign learn = upd_tick & good & ~force_free;

  always_ff @(posedge clk) begin
    if (!rst_n)        last_word <= NOM_WORD;
    else if (upd_tick) last_word <= loop_word;
  end

  dmc_lock_qual #(.CNT_W(CNT_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(upd_tick), .good(good),
    .force_fr(force_free), .lock_ticks(lock_ticks), .qual(qual)
  );

  dmc_hold_avg #(.FW_W(FW_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .NOM_WORD(NOM_WORD)) u_avg (
    .clk(clk), .rst_n(rst_n), .mode(mode), .learn(learn), .word(loop_word),
    .shift(avg_shift), .hold_min(hold_min), .avg(avg), .hold_ok(hold_ok)
  );

  dmc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(upd_tick), .good(good),
    .force_fr(force_free), .qual(qual), .hold_ok(hold_ok), .mode(mode)
  );

  always_comb begin
    unique case (mode)
      MODE_LOCK: nco_word = last_word;
      MODE_HOLD: nco_word = avg;
      default:   nco_word = NOM_WORD;
    endcase
  end

  assign mode_code = mode;

  // R6: Free-Run always drives the nominal word
  p_free_nominal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b00) |-> (nco_word == NOM_WORD));

  // R3: Locked output tracks the word of the previous strobe
  p_lock_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b01 && $past(upd_tick)) |-> (nco_word == $past(loop_word)));
endmodule

// File: tb/dpll_mode_ctrl_bench.sv
module dpll_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW_W = 24;
  localparam int SHIFT_W = 5;
  localparam int CNT_W = 16;
  localparam logic [FW_W-1:0] NOM = 24'h800000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_tick = 1'b0;
  logic [FW_W-1:0] loop_word = NOM;
  logic ref_ok = 1'b0;
  logic lock_in = 1'b0;
  logic force_free = 1'b0;
  logic [CNT_W-1:0] lock_ticks = 16'd4;
  logic [CNT_W-1:0] hold_min = 16'd6;
  logic [SHIFT_W-1:0] avg_shift = 5'd2;
  logic [FW_W-1:0] nco_word;
  logic [1:0] mode_code;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpll_mode_ctrl #(.FW_W(FW_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .NOM_WORD(NOM)) u_dpll_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .loop_word(loop_word),
    .ref_ok(ref_ok), .lock_in(lock_in), .force_free(force_free),
    .lock_ticks(lock_ticks), .hold_min(hold_min), .avg_shift(avg_shift),
    .nco_word(nco_word), .mode_code(mode_code)
  );

  // reference model state
  logic [1:0] m_mode;
  longint m_cnt, m_upd, m_avg, m_last;

  function automatic longint avg_next(longint a, longint w, int s);
    longint d;
    d = w - a;
    return a + (d >>> s);
  endfunction

  function automatic logic [FW_W-1:0] exp_out(logic [1:0] md, longint av, longint lw);
    if (md == 2'b01) return lw[FW_W-1:0];
    if (md == 2'b10) return av[FW_W-1:0];
    return NOM;
  endfunction

  always @(posedge clk) begin
    logic [1:0] n;
    logic g;
    longint cn;
    if (!rst_n) begin
      m_mode = 2'b00; m_cnt = 0; m_upd = 0; m_avg = NOM; m_last = NOM;
    end else begin
      g = ref_ok && lock_in;
      n = m_mode;
      cn = (m_cnt == 65535) ? m_cnt : m_cnt + 1;
      if (force_free) n = 2'b00;
      else if (upd_tick) begin
        case (m_mode)
          2'b00: if (g && cn >= lock_ticks) n = 2'b01;
          2'b01: if (!g) n = (m_upd >= hold_min) ? 2'b10 : 2'b00;
          default: if (g) n = 2'b01;
        endcase
      end
      if (m_mode == 2'b00) begin
        m_avg = NOM; m_upd = 0;
      end else if (m_mode == 2'b01 && upd_tick && g && !force_free) begin
        m_avg = avg_next(m_avg, loop_word, avg_shift);
        if (m_upd < 65535) m_upd = m_upd + 1;
      end
      if (force_free) m_cnt = 0;
      else if (upd_tick) m_cnt = g ? cn : 0;
      if (upd_tick) m_last = loop_word;
      m_mode = n;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_model(string tag);
    chk({tag, " mode"}, {30'd0, mode_code}, {30'd0, m_mode});
    chk({tag, " word"}, {8'd0, nco_word}, {8'd0, exp_out(m_mode, m_avg, m_last)});
  endtask

  // one clock: inputs already set, advance, then sample at negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick_with(logic r, logic l, logic [FW_W-1:0] w);
    upd_tick = 1'b1; ref_ok = r; lock_in = l; loop_word = w;
    step();
    upd_tick = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 mode", {30'd0, mode_code}, 32'd0);
    chk("R1 word", {8'd0, nco_word}, {8'd0, NOM});

    // R2: three qualifying strobes are not enough, fourth locks
    for (int i = 0; i < 3; i++) tick_with(1, 1, NOM + 24'd100);
    chk("R2 early", {30'd0, mode_code}, 32'd0);
    tick_with(1, 0, NOM);            // break restarts count
    for (int i = 0; i < 3; i++) tick_with(1, 1, NOM + 24'd100);
    chk("R2 restart", {30'd0, mode_code}, 32'd0);
    tick_with(1, 1, NOM + 24'd200);
    chk("R2 lock", {30'd0, mode_code}, 32'd1);
    chk("R3 follow", {8'd0, nco_word}, {8'd0, NOM + 24'd200});

    // R6: loss after only 2 updates (hold_min=6) falls to Free-Run
    tick_with(1, 1, NOM + 24'd300);
    tick_with(1, 1, NOM + 24'd400);
    tick_with(0, 1, NOM);
    chk("R6 mode", {30'd0, mode_code}, 32'd0);
    chk("R6 word", {8'd0, nco_word}, {8'd0, NOM});

    // relock, then exactly hold_min updates
    lock_ticks = 16'd1;
    tick_with(1, 1, NOM + 24'd1000);
    chk("R2 one", {30'd0, mode_code}, 32'd1);
    for (int i = 0; i < 5; i++) tick_with(1, 1, NOM + 24'd1000 + 24'(i * 40));
    cmp_model("R4 pre");
    // R10: activity without a strobe is ignored
    ref_ok = 0; lock_in = 0; loop_word = 24'h000123;
    step(); step();
    chk("R10 mode", {30'd0, mode_code}, 32'd1);
    chk("R10 word", {8'd0, nco_word}, {8'd0, NOM + 24'd1160});
    tick_with(1, 1, NOM + 24'd2000);   // sixth update
    tick_with(0, 0, NOM);
    chk("R5 hold", {30'd0, mode_code}, 32'd2);
    cmp_model("R4 avg");
    tick_with(1, 0, NOM + 24'd5000);
    tick_with(0, 1, NOM + 24'd5000);
    cmp_model("R4 frozen");
    // R7: immediate relock
    lock_ticks = 16'd9;
    tick_with(1, 1, NOM + 24'd777);
    chk("R7 relock", {30'd0, mode_code}, 32'd1);
    // R8: force
    force_free = 1; step();
    chk("R8 force", {30'd0, mode_code}, 32'd0);
    chk("R8 word", {8'd0, nco_word}, {8'd0, NOM});
    lock_ticks = 16'd0;
    tick_with(1, 1, NOM + 24'd5);
    chk("R8 block", {30'd0, mode_code}, 32'd0);
    force_free = 0;

    // constrained random phases
    for (int ph = 0; ph < 8; ph++) begin
      lock_ticks = 16'($urandom_range(0, 5));
      hold_min = 16'($urandom_range(0, 8));
      avg_shift = 5'($urandom_range(0, 7));
      for (int c = 0; c < 600; c++) begin
        upd_tick = ($urandom_range(0, 1) == 1);
        ref_ok = ($urandom_range(0, 15) != 0);
        lock_in = ($urandom_range(0, 9) != 0);
        force_free = ($urandom_range(0, 99) == 0);
        loop_word = NOM + 24'($urandom_range(0, 65535)) - 24'd32768;
        step();
        cmp_model(m_mode == 2'b10 ? "R4 R5 R9 rand" :
                  m_mode == 2'b01 ? "R3 R7 R9 rand" : "R2 R6 R8 rand");
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule